// File: doc/BRIEF.md
# Host Interrupt Moderation and Async-Advance Doorbell

This block sits in the command path of a USB 2.0 host controller. It holds a software-writable command word and shapes when the controller may raise its interrupt. The command word carries three fields: an interrupt threshold, an asynchronous schedule enable, and a doorbell bit. Software rings the doorbell to ask the schedule engine to confirm that it has dropped cached asynchronous list state. When the engine returns an eviction pulse, the block sets an async-advance status bit. One cycle later it clears the doorbell.

Interrupts are moderated. A micro-frame counter counts tick pulses and marks a boundary every N ticks, where N is the threshold code: 1, 2, 4, 8, 16, 32 or 64. A pending, enabled status bit raises the interrupt output only at the first boundary after the status was latched. Software clears the status by writing a one to it, which drops the interrupt.

Two small state machines drive the behaviour. The doorbell machine has three states:

- `DB_IDLE`: no doorbell.
- `DB_WAIT`: the doorbell is set and the block waits for eviction.
- `DB_HANDOFF`: the status has just been set and the doorbell is being cleared.

Its transitions are as follows:

- ring: `DB_IDLE` to `DB_WAIT`.
- evict-accept: `DB_WAIT` to `DB_HANDOFF`. This needs the schedule enabled.
- release: `DB_HANDOFF` to `DB_IDLE`.
- re-ring: `DB_HANDOFF` to `DB_WAIT`.

The interrupt machine also has three states:

- `IRQ_QUIET`: the status is clear or the enable is off.
- `IRQ_ARMED`: the status is pending and the block waits for a boundary.
- `IRQ_FIRE`: the interrupt output is high.

Its transitions are as follows:

- pend: `IRQ_QUIET` to `IRQ_ARMED`.
- fire: `IRQ_ARMED` to `IRQ_FIRE` on a boundary. If a boundary falls in the same cycle as pend, the machine goes straight from `IRQ_QUIET` to `IRQ_FIRE`.
- retire: `IRQ_ARMED` or `IRQ_FIRE` back to `IRQ_QUIET`, when the status or the enable goes away.

Top module: `usbh_irq_moderator`

## Requirements
- R1: After reset the command readback is 0x0008_0000. That is threshold code 08h, schedule enable 0 and doorbell 0. The status, the interrupt enable, `async_en` and `irq` are all 0.
- R2: The threshold field is `cmd_wr_data[23:16]`. A write of 01h, 02h, 04h, 08h, 10h, 20h or 40h loads it. Any other code, 00h included, leaves the previous value unchanged.
- R3: The readback carries only bits 23:16, bit 6 and bit 5. Every other bit reads 0 whatever was written.
- R4: Bit 6 is the doorbell. Writing 1 sets it and writing 0 leaves it unchanged. Its state reads back in bit 6.
- R5: Bit 5 is the schedule enable and drives `async_en`. An `evict_done` pulse while the doorbell is set and bit 5 is 1 sets `adv_status` after that edge. The doorbell reads 0 one cycle later.
- R6: An `evict_done` pulse is ignored when the doorbell is 0. With bit 5 at 0, a rung doorbell stays set and eviction never sets the status.
- R7: A boundary occurs on the tick that brings the tick count since the last boundary up to the threshold code. A write that changes the threshold restarts the count from zero.
- R8: With the enable at 1, `irq` rises only at the first boundary that is sampled after `adv_status` already reads 1. A boundary in the same edge that sets the status does not count.
- R9: `sts_w1c` clears the status, and `irq` then reads 0 after that edge. Loading the enable with 0 (`ien_we`, `ien_d`=0) also drops `irq` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wr_data | input | 32 | Command word write data |
| cmd_rd_data | output | 32 | Command word readback |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_d | input | 1 | Interrupt-enable write value |
| sts_w1c | input | 1 | Write-one-to-clear of the async-advance status |
| uframe_tick | input | 1 | One pulse per micro-frame |
| evict_done | input | 1 | Schedule engine has evicted cached async state |
| async_en | output | 1 | Schedule engine may process the async list |
| adv_status | output | 1 | Async-advance status bit |
| ien | output | 1 | Interrupt-enable bit |
| irq | output | 1 | Moderated interrupt output |

## Verification
A doorbell machine stuck in a wrong state shows up within one or two cycles of an eviction pulse. The symptom is `adv_status` failing to rise, or doorbell bit 6 not falling in the cycle after the status rises. A miscounting micro-frame counter moves the rise of `irq` to the wrong tick, and it does so within one threshold period of the status being set. For that reason the bench counts ticks to the exact edge, uses both short and default thresholds, and covers a threshold change in the middle of a count. A wrong interrupt state either raises `irq` on the edge that sets the status or leaves it high after a clear, and both are visible one edge later.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
    typedef enum logic [1:0] {
        DB_IDLE    = 2'd0,
        DB_WAIT    = 2'd1,
        DB_HANDOFF = 2'd2
    } db_state_e;

    typedef enum logic [1:0] {
        IRQ_QUIET = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_FIRE  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg #(
    parameter int DATA_W    = 32,
    parameter int THR_W     = 8,
    parameter int THR_LSB   = 16,
    parameter int ASYNC_BIT = 5,
    parameter int DB_BIT    = 6,
    parameter int THR_RST   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              doorbell,
    output logic [THR_W-1:0]  thr_code,
    output logic              async_en,
    output logic              ring,
    output logic              thr_restart,
    output logic [DATA_W-1:0] rd_data
);
    localparam int THR_MSB = THR_LSB + THR_W - 1;

    logic [THR_W-1:0] new_code;
    logic             code_legal;

    assign new_code   = wr_data[THR_MSB:THR_LSB];
    // Legal codes are one-hot and never use the top bit (max 64 with 8 bits)
    assign code_legal = $onehot(new_code) && !new_code[THR_W-1];
    assign ring       = wr_en && wr_data[DB_BIT];
    assign thr_restart = wr_en && code_legal && (new_code != thr_code);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_code <= THR_W'(THR_RST);
            async_en <= 1'b0;
        end else if (wr_en) begin
            async_en <= wr_data[ASYNC_BIT];
            if (code_legal)
                thr_code <= new_code;
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[THR_MSB:THR_LSB] = thr_code;
        rd_data[ASYNC_BIT]       = async_en;
        rd_data[DB_BIT]          = doorbell;
    end

    assert_thr_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(thr_code) && !thr_code[THR_W-1]);
    assert_thr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !code_legal) |=> $stable(thr_code));
endmodule

// File: rtl/usbh_uframe_timer.sv
module usbh_uframe_timer #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [THR_W-1:0] thr_code,
    output logic             boundary
);
    logic [THR_W-1:0] cnt;
    logic [THR_W-1:0] cnt_inc;

    assign cnt_inc  = cnt + THR_W'(1);
    assign boundary = tick && !restart && (cnt_inc == thr_code);

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (boundary)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_inc;
    end

    assert_cnt_below_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < thr_code);
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/usbh_doorbell_fsm.sv
module usbh_doorbell_fsm
    import usbh_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic async_en,
    input  logic evict,
    output logic doorbell,
    output logic sts_set
);
    db_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DB_IDLE:    if (ring) state_nx = DB_WAIT;
            DB_WAIT:    if (async_en && evict) state_nx = DB_HANDOFF;
            DB_HANDOFF: state_nx = ring ? DB_WAIT : DB_IDLE;
            default:    state_nx = DB_IDLE;
        endcase
    end

    always_comb begin
        doorbell = (state != DB_IDLE);
        sts_set  = (state == DB_WAIT) && async_en && evict;
    end

    assert_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DB_WAIT && !async_en) |=> (state == DB_WAIT));
    assert_handoff_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DB_HANDOFF && !ring) |=> !doorbell);
endmodule

// File: rtl/usbh_irq_gate.sv
module usbh_irq_gate
    import usbh_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sts_set,
    input  logic sts_w1c,
    input  logic ien_we,
    input  logic ien_d,
    input  logic boundary,
    output logic sts_q,
    output logic ien_q,
    output logic irq
);
    irq_state_e state, state_nx;
    logic       live;

    assign live = sts_q && ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
            ien_q <= 1'b0;
            state <= IRQ_QUIET;
        end else begin
            // a set in the same cycle as a clear wins
            if (sts_set)      sts_q <= 1'b1;
            else if (sts_w1c) sts_q <= 1'b0;
            if (ien_we)       ien_q <= ien_d;
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET: if (live) state_nx = boundary ? IRQ_FIRE : IRQ_ARMED;
            IRQ_ARMED: if (!live) state_nx = IRQ_QUIET;
                       else if (boundary) state_nx = IRQ_FIRE;
            IRQ_FIRE:  if (!live) state_nx = IRQ_QUIET;
            default:   state_nx = IRQ_QUIET;
        endcase
    end

    always_comb irq = (state == IRQ_FIRE) && live;

    assert_irq_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(boundary));
    assert_irq_drop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_w1c && !sts_set) |=> !irq);
    assert_irq_drop_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_we && !ien_d) |=> !irq);
endmodule

// File: rtl/usbh_irq_moderator.sv
module usbh_irq_moderator #(
    parameter int DATA_W    = 32,
    parameter int THR_W     = 8,
    parameter int THR_LSB   = 16,
    parameter int ASYNC_BIT = 5,
    parameter int DB_BIT    = 6,
    parameter int THR_RST   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [DATA_W-1:0] cmd_wr_data,
    output logic [DATA_W-1:0] cmd_rd_data,
    input  logic              ien_we,
    input  logic              ien_d,
    input  logic              sts_w1c,
    input  logic              uframe_tick,
    input  logic              evict_done,
    output logic              async_en,
    output logic              adv_status,
    output logic              ien,
    output logic              irq
);
    logic [THR_W-1:0] thr_code;
    logic ring, thr_restart, doorbell, sts_set, boundary;

    usbh_cmd_reg #(
        .DATA_W(DATA_W), .THR_W(THR_W), .THR_LSB(THR_LSB),
        .ASYNC_BIT(ASYNC_BIT), .DB_BIT(DB_BIT), .THR_RST(THR_RST)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
        .doorbell(doorbell), .thr_code(thr_code), .async_en(async_en),
        .ring(ring), .thr_restart(thr_restart), .rd_data(cmd_rd_data)
    );

    usbh_uframe_timer #(.THR_W(THR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .restart(thr_restart),
        .thr_code(thr_code), .boundary(boundary)
    );

    usbh_doorbell_fsm u_db (
        .clk(clk), .rst_n(rst_n), .ring(ring), .async_en(async_en),
        .evict(evict_done), .doorbell(doorbell), .sts_set(sts_set)
    );

    usbh_irq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .sts_set(sts_set), .sts_w1c(sts_w1c),
        .ien_we(ien_we), .ien_d(ien_d), .boundary(boundary),
        .sts_q(adv_status), .ien_q(ien), .irq(irq)
    );

    assert_status_needs_sched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adv_status) |-> ($past(async_en) && $past(evict_done)));
endmodule

// File: tb/tb_usbh_irq_moderator.sv
module tb_usbh_irq_moderator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [31:0] cmd_wr_data = '0;
    logic [31:0] cmd_rd_data;
    logic        ien_we = 1'b0, ien_d = 1'b0, sts_w1c = 1'b0;
    logic        uframe_tick = 1'b0, evict_done = 1'b0;
    logic        async_en, adv_status, ien, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usbh_irq_moderator dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .cmd_rd_data(cmd_rd_data), .ien_we(ien_we), .ien_d(ien_d), .sts_w1c(sts_w1c),
        .uframe_tick(uframe_tick), .evict_done(evict_done), .async_en(async_en),
        .adv_status(adv_status), .ien(ien), .irq(irq)
    );

    typedef struct packed {
        logic        cwe;
        logic [31:0] cd;
        logic        iwe;
        logic        id;
        logic        w1c;
        logic        tick;
        logic        ev;
        logic        e_irq;
        logic        e_sts;
        logic [31:0] e_rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0002_0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0020},
        '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0020},
        '{1'b1, 32'h0002_0060, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0060},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0002_0060},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0002_0020},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0002_0020},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0002_0020},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0020},
        '{1'b1, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_0020},
        '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0002_0020}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // apply the currently driven inputs across one rising edge, then idle them
    task automatic cyc();
        @(posedge clk);
        #1;
        cmd_wr_en = 1'b0; cmd_wr_data = '0; ien_we = 1'b0; ien_d = 1'b0;
        sts_w1c = 1'b0; uframe_tick = 1'b0; evict_done = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        cmd_wr_en = 1'b1; cmd_wr_data = d; cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            uframe_tick = 1'b1; cyc();
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 readback", cmd_rd_data, 32'h0008_0000);
        chk("R1 flags", {28'd0, async_en, adv_status, ien, irq}, 32'h0);

        // table: R2 R4 R5 R6 R7 R8 R9 main flow
        for (int v = 0; v < NV; v++) begin
            cmd_wr_en = VECS[v].cwe; cmd_wr_data = VECS[v].cd;
            ien_we = VECS[v].iwe; ien_d = VECS[v].id; sts_w1c = VECS[v].w1c;
            uframe_tick = VECS[v].tick; evict_done = VECS[v].ev;
            cyc();
            chk($sformatf("R5/R8 vec%0d rd", v), cmd_rd_data, VECS[v].e_rd);
            chk($sformatf("R8/R9 vec%0d irq", v), {31'd0, irq}, {31'd0, VECS[v].e_irq});
            chk($sformatf("R5/R6 vec%0d sts", v), {31'd0, adv_status}, {31'd0, VECS[v].e_sts});
        end

        // R8 boundary coinciding with the status set does not count (thr 2, cnt 0)
        wr(32'h0002_0060);
        ticks(1);
        uframe_tick = 1'b1; evict_done = 1'b1; cyc();
        chk("R8 coincident sts", {31'd0, adv_status}, 32'd1);
        chk("R8 coincident irq", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R8 mid irq", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R8 next boundary irq", {31'd0, irq}, 32'd1);
        ien_we = 1'b1; ien_d = 1'b0; cyc();
        chk("R9 ien off drops irq", {31'd0, irq}, 32'd0);
        sts_w1c = 1'b1; ien_we = 1'b1; ien_d = 1'b1; cyc();
        chk("R9 w1c clears", {30'd0, adv_status, irq}, 32'd0);

        // R7 restart on threshold change, default code 08h
        wr(32'h0004_0060);
        evict_done = 1'b1; cyc();
        cyc();
        ticks(2);
        wr(32'h0008_0020);
        ticks(7);
        chk("R7 restarted no irq after 7", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R7 irq at 8th tick", {31'd0, irq}, 32'd1);
        sts_w1c = 1'b1; cyc();
        chk("R9 clear", {31'd0, irq}, 32'd0);

        // R6 doorbell with schedule disabled
        wr(32'h0008_0000);
        chk("R5 async_en low", {31'd0, async_en}, 32'd0);
        wr(32'h0008_0040);
        evict_done = 1'b1; cyc();
        chk("R6 no status when disabled", {31'd0, adv_status}, 32'd0);
        chk("R6 doorbell held", cmd_rd_data, 32'h0008_0040);
        wr(32'h0008_0020);
        chk("R4 write 0 keeps doorbell", cmd_rd_data, 32'h0008_0060);
        evict_done = 1'b1; cyc();
        chk("R5 status after evict", {31'd0, adv_status}, 32'd1);
        chk("R5 doorbell still set", cmd_rd_data[6], 1'b1);
        cyc();
        chk("R5 doorbell released", cmd_rd_data, 32'h0008_0020);
        sts_w1c = 1'b1; cyc();

        // R3 reserved bits
        wr(32'hFF01_FFBF);
        chk("R3 reserved read zero", cmd_rd_data, 32'h0001_0020);
        chk("R5 async_en high", {31'd0, async_en}, 32'd1);

        // R2 illegal codes keep previous
        wr(32'h0003_0020);
        chk("R2 code 03h rejected", cmd_rd_data, 32'h0001_0020);
        wr(32'h0080_0020);
        chk("R2 code 80h rejected", cmd_rd_data, 32'h0001_0020);
        wr(32'h0040_0020);
        chk("R2 code 40h accepted", cmd_rd_data, 32'h0040_0020);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule